// File: doc/BRIEF.md
# Power-Good Strap Latch and Power-Down Sequencer

This block sequences the start-up and power-down of a clock generator. Once the supply-ready indication arrives, it waits out a settling delay and then watches an active-low power-good pin. On the first low sample it freezes the frequency-select and configuration straps, reports them as status, decodes the CPU frequency code, and lets the clock outputs run. From that moment the same pin is read as an active-high power-down request.

A power-down request only takes effect when it is seen high on two rising edges of the CPU complement clock in a row. The block then parks the outputs: single-ended outputs are held low at their next falling edge, and each differential output is held high or floated, as its drive-mode input chooses. Once everything is parked the oscillators are turned off. When the request is released the oscillators restart, and after a relock timer the holds are released. A test strap, which stands for the frequency-select C pin being above its high threshold at the latch, keeps the straps transparent and turns off the power-down function. Clock edges arrive as one-cycle strobes on the sequencer's core clock, and the analog PLL is modelled by timers.

Top module: `pgood_strap_seq`

## Requirements
- R1: After `rst_n` is released, `strap_vld`, `out_en`, `vco_en`, `se_hold` and every bit of `dif_hold_hi` and `dif_hold_z` are 0.
- R2: After `supply_ok` is seen high, the pin is not sampled for `DLY_CYC` core cycles. A low pin during that delay is latched only after the delay has run out.
- R3: The first low sample of the synchronized pin latches `fs_lat` = {fs_c, fs_b, fs_a}, `itp_lat`, `sel96_lat`, `req_lat` and `test_mode`, and sets `strap_vld` and `out_en`.
- R4: Outside test mode, strap pin changes after the latch have no effect, and the pin going low again does not re-latch.
- R5: `cpu_freq` decodes `fs_lat` as 3'b101→0 (100 MHz), 3'b001→1 (133 MHz), 3'b011→2 (166 MHz) and 3'b010→3 (200 MHz), with `freq_ok`=1. Every other value gives `cpu_freq`=0 and `freq_ok`=0.
- R6: If `fs_c_hi` is 1 at the latch, `test_mode` is 1. While the pin is low, the strap latches follow the pins. A high pin never powers the block down.
- R7: Power-down is qualified only when the synchronized pin is high at two consecutive `ckc_rise` strobes. `out_en` drops after the second strobe. A single strobe, or two strobes with a low sample between them, has no effect.
- R8: After qualification, `se_hold` rises at the next `se_fall` strobe. A `se_fall` in the same cycle as the qualifying `ckc_rise` does not count.
- R9: After qualification, the differential outputs park at the next `ckc_fall`, and no more than 4 `ckc_rise` strobes may pass first. Output i raises `dif_hold_hi[i]` when `dif_tri_mode[i]`=0, or `dif_hold_z[i]` when it is 1.
- R10: `vco_en` drops only once `se_hold` and the differential park are both in place.
- R11: When the pin goes low while powered down, `vco_en` returns to 1. After `RELOCK_CYC` cycles all holds clear and `out_en` returns to 1. The default is 200000 cycles, 1.6 ms at 125 MHz, which is inside 1.8 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer core clock |
| rst_n | input | 1 | Active-low reset |
| supply_ok | input | 1 | Supply-ready indication |
| pg_pd_pin | input | 1 | Power-good (active low), later power-down (active high), asynchronous |
| fs_a | input | 1 | Frequency-select strap A |
| fs_b | input | 1 | Frequency-select strap B |
| fs_c | input | 1 | Frequency-select strap C |
| fs_c_hi | input | 1 | Strap C above test threshold |
| itp_strap | input | 1 | Debug-port CPU output strap |
| sel96_strap | input | 1 | 96/100 MHz select strap |
| req_strap | input | 1 | Request-pin function strap |
| ckc_rise | input | 1 | Strobe: CPU complement clock rising edge |
| ckc_fall | input | 1 | Strobe: differential complement falling edge |
| se_fall | input | 1 | Strobe: single-ended clock falling edge |
| dif_tri_mode | input | NDIF | Per-output park mode, 1 = float |
| strap_vld | output | 1 | Straps latched |
| fs_lat | output | 3 | Latched {fs_c, fs_b, fs_a} |
| itp_lat | output | 1 | Latched debug-port strap |
| sel96_lat | output | 1 | Latched 96/100 select |
| req_lat | output | 1 | Latched request-pin strap |
| test_mode | output | 1 | Test mode active |
| cpu_freq | output | 2 | CPU frequency code |
| freq_ok | output | 1 | Strap combination is a listed one |
| vco_en | output | 1 | Oscillator/VCO enable |
| out_en | output | 1 | Clock outputs running |
| se_hold | output | 1 | Hold single-ended outputs low |
| dif_hold_hi | output | NDIF | Hold differential output high |
| dif_hold_z | output | NDIF | Float differential output |

## Verification
Two events can fall in the same cycle: the `ckc_rise` strobe that qualifies power-down and a `se_fall` strobe. The bench raises both strobes in one cycle. It expects `se_hold` to stay low, since that falling edge came before the park began, and to rise only at the following `se_fall`. The bench also gives a pair of high samples broken by a low sample between two rising strobes, and expects the outputs to keep running.

// File: rtl/pgood_strap_seq.sv
module pgood_strap_seq #(
  parameter int DLY_CYC    = 31250,
  parameter int RELOCK_CYC = 200000,
  parameter int NDIF       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_ok,
  input  logic            pg_pd_pin,
  input  logic            fs_a,
  input  logic            fs_b,
  input  logic            fs_c,
  input  logic            fs_c_hi,
  input  logic            itp_strap,
  input  logic            sel96_strap,
  input  logic            req_strap,
  input  logic            ckc_rise,
  input  logic            ckc_fall,
  input  logic            se_fall,
  input  logic [NDIF-1:0] dif_tri_mode,
  output logic            strap_vld,
  output logic [2:0]      fs_lat,
  output logic            itp_lat,
  output logic            sel96_lat,
  output logic            req_lat,
  output logic            test_mode,
  output logic [1:0]      cpu_freq,
  output logic            freq_ok,
  output logic            vco_en,
  output logic            out_en,
  output logic            se_hold,
  output logic [NDIF-1:0] dif_hold_hi,
  output logic [NDIF-1:0] dif_hold_z
);
  localparam int DW = $clog2(DLY_CYC + 1);
  localparam int RW = $clog2(RELOCK_CYC + 1);
  localparam int TW = (DW > RW) ? DW : RW;

  typedef enum logic [2:0] {
    S_SUPPLY, S_DELAY, S_WAITPG, S_RUN, S_PARK, S_OFF, S_RELOCK
  } st_t;

  st_t          st;
  logic [1:0]   pin_sy;
  logic [TW-1:0] tmr;
  logic         qual;
  logic         dif_done;
  logic         latch_now;
  wire          pin_s = pin_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sy <= 2'b11;
    else        pin_sy <= {pin_sy[0], pg_pd_pin};

  assign latch_now = !pin_s && (st == S_WAITPG || (st == S_RUN && test_mode));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_lat    <= '0;
      itp_lat   <= 1'b0;
      sel96_lat <= 1'b0;
      req_lat   <= 1'b0;
      test_mode <= 1'b0;
      strap_vld <= 1'b0;
    end else if (latch_now) begin
      fs_lat    <= {fs_c, fs_b, fs_a};
      itp_lat   <= itp_strap;
      sel96_lat <= sel96_strap;
      req_lat   <= req_strap;
      test_mode <= fs_c_hi;
      strap_vld <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_SUPPLY;
      tmr      <= '0;
      qual     <= 1'b0;
      se_hold  <= 1'b0;
      dif_done <= 1'b0;
    end else begin
      case (st)
        S_SUPPLY: if (supply_ok) begin st <= S_DELAY; tmr <= '0; end
        S_DELAY:
          if (tmr == TW'(DLY_CYC - 1)) st <= S_WAITPG;
          else tmr <= tmr + 1'b1;
        S_WAITPG: if (!pin_s) begin st <= S_RUN; qual <= 1'b0; end
        S_RUN:
          if (!test_mode && ckc_rise) begin
            if (!pin_s)    qual <= 1'b0;
            else if (qual) begin qual <= 1'b0; st <= S_PARK; end
            else           qual <= 1'b1;
          end
        S_PARK: begin
          if (se_fall)  se_hold  <= 1'b1;
          if (ckc_fall) dif_done <= 1'b1;
          if ((se_hold || se_fall) && (dif_done || ckc_fall)) st <= S_OFF;
        end
        S_OFF: if (!pin_s) begin st <= S_RELOCK; tmr <= '0; end
        S_RELOCK:
          if (tmr == TW'(RELOCK_CYC - 1)) begin
            st       <= S_RUN;
            se_hold  <= 1'b0;
            dif_done <= 1'b0;
          end else tmr <= tmr + 1'b1;
        default: st <= S_SUPPLY;
      endcase
    end

  always_comb begin
    freq_ok  = 1'b1;
    case (fs_lat)
      3'b101:  cpu_freq = 2'd0;
      3'b001:  cpu_freq = 2'd1;
      3'b011:  cpu_freq = 2'd2;
      3'b010:  cpu_freq = 2'd3;
      default: begin cpu_freq = 2'd0; freq_ok = 1'b0; end
    endcase
  end

  assign vco_en      = (st != S_SUPPLY) && (st != S_OFF);
  assign out_en      = (st == S_RUN);
  assign dif_hold_hi = {NDIF{dif_done}} & ~dif_tri_mode;
  assign dif_hold_z  = {NDIF{dif_done}} &  dif_tri_mode;

  logic [2:0] pk_age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pk_age <= '0;
    else if (st != S_PARK || dif_done) pk_age <= '0;
    else if (ckc_rise && pk_age != 3'd7) pk_age <= pk_age + 1'b1;

  a_r3_latch_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_vld) |-> $past(!pin_s) && $past(st == S_WAITPG));
  a_r4_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_vld && $past(strap_vld) && !$past(test_mode))
      |-> $stable({fs_lat, itp_lat, sel96_lat, req_lat, test_mode}));
  a_r6_test_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && strap_vld) |-> out_en);
  a_r7_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en) |-> $past(ckc_rise) && $past(pin_s) && $past(qual));
  a_r9_park_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PARK && !dif_done) |-> pk_age <= 3'd4);
  a_r10_vco_after_park: assert property (@(posedge clk) disable iff (!rst_n)
    (!vco_en && strap_vld) |-> se_hold && ((dif_hold_hi | dif_hold_z) == {NDIF{1'b1}}));
  a_r11_holds_off_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !se_hold && dif_hold_hi == '0 && dif_hold_z == '0);
endmodule

// File: tb/test_pgood_strap_seq.sv
`timescale 1ns/1ps
module test_pgood_strap_seq;
  localparam int DLY = 20;
  localparam int RLK = 50;
  localparam int ND  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 0, pin = 1, fs_a = 0, fs_b = 0, fs_c = 0, fs_c_hi = 0;
  logic itp = 0, s96 = 0, req = 0, ckr = 0, ckf = 0, sef = 0;
  logic [ND-1:0] tri_m = '0;
  logic strap_vld, itp_lat, sel96_lat, req_lat, test_mode, freq_ok, vco_en, out_en, se_hold;
  logic [2:0] fs_lat;
  logic [1:0] cpu_freq;
  logic [ND-1:0] d_hi, d_z;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pgood_strap_seq #(.DLY_CYC(DLY), .RELOCK_CYC(RLK), .NDIF(ND)) i_pgood_strap_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_pd_pin(pin),
    .fs_a(fs_a), .fs_b(fs_b), .fs_c(fs_c), .fs_c_hi(fs_c_hi),
    .itp_strap(itp), .sel96_strap(s96), .req_strap(req),
    .ckc_rise(ckr), .ckc_fall(ckf), .se_fall(sef), .dif_tri_mode(tri_m),
    .strap_vld(strap_vld), .fs_lat(fs_lat), .itp_lat(itp_lat), .sel96_lat(sel96_lat),
    .req_lat(req_lat), .test_mode(test_mode), .cpu_freq(cpu_freq), .freq_ok(freq_ok),
    .vco_en(vco_en), .out_en(out_en), .se_hold(se_hold),
    .dif_hold_hi(d_hi), .dif_hold_z(d_z));

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req_s, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic r, input logic f, input logic s);
    ckr = r; ckf = f; sef = s;
    cyc(1);
    ckr = 0; ckf = 0; sef = 0;
    cyc(1);
  endtask

  task automatic do_reset();
    rst_n = 0; supply_ok = 0; pin = 1; fs_c_hi = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic powerup(input logic [2:0] fs, input logic hi);
    {fs_c, fs_b, fs_a} = fs; fs_c_hi = hi;
    supply_ok = 1; pin = 0;
    cyc(DLY + 6);
  endtask

  function automatic logic [2:0] exp_freq(input logic [2:0] fs);
    case (fs)
      3'b101: return {1'b1, 2'd0};
      3'b001: return {1'b1, 2'd1};
      3'b011: return {1'b1, 2'd2};
      3'b010: return {1'b1, 2'd3};
      default: return 3'b000;
    endcase
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 strap_vld", strap_vld, 0);
    chk("R1 out_en/vco_en", {out_en, vco_en}, 0);
    chk("R1 holds", {se_hold, d_hi, d_z}, 0);
  endtask

  task automatic t_delay();
    do_reset();
    {fs_c, fs_b, fs_a} = 3'b001; itp = 1; s96 = 1; req = 0;
    supply_ok = 1; pin = 0;
    cyc(DLY - 2);
    chk("R2 no latch during delay", strap_vld, 0);
    chk("R2 vco on in delay", vco_en, 1);
    cyc(8);
    chk("R3 latched after delay", strap_vld, 1);
    chk("R3 fs_lat", fs_lat, 3'b001);
    chk("R3 side straps", {itp_lat, sel96_lat, req_lat, test_mode}, 4'b1100);
    chk("R3 out_en", out_en, 1);
    chk("R5 freq 133", {freq_ok, cpu_freq}, exp_freq(3'b001));
  endtask

  task automatic t_frozen();
    {fs_c, fs_b, fs_a} = 3'b110; itp = 0; s96 = 0; req = 1;
    pin = 1; cyc(4); pin = 0; cyc(4);
    chk("R4 fs frozen", fs_lat, 3'b001);
    chk("R4 side frozen", {itp_lat, sel96_lat, req_lat}, 3'b110);
    chk("R4 still running", out_en, 1);
  endtask

  task automatic t_decode();
    for (int k = 0; k < 8; k++) begin
      do_reset();
      powerup(k[2:0], 0);
      chk("R5 decode", {freq_ok, cpu_freq}, exp_freq(k[2:0]));
    end
  endtask

  task automatic t_broken_pair();
    pin = 1; cyc(4);
    strobe(1, 0, 0);
    pin = 0; cyc(4);
    strobe(1, 0, 0);
    pin = 1; cyc(4);
    strobe(1, 0, 0);
    chk("R7 single/broken pair ignored", out_en, 1);
  endtask

  task automatic t_powerdown();
    do_reset();
    tri_m = 3'b101;
    powerup(3'b011, 0);
    t_broken_pair();
    ckr = 1; sef = 1; cyc(1); ckr = 0; sef = 0; cyc(1);
    chk("R7 qualified", out_en, 0);
    chk("R8 coincident se_fall ignored", se_hold, 0);
    strobe(0, 1, 0);
    chk("R9 hold high", d_hi, 3'b010);
    chk("R9 hold float", d_z, 3'b101);
    chk("R10 vco still on", vco_en, 1);
    strobe(0, 0, 1);
    chk("R8 se hold", se_hold, 1);
    cyc(1);
    chk("R10 vco off", vco_en, 0);
    pin = 0; cyc(5);
    chk("R11 vco restarted", vco_en, 1);
    chk("R11 holds kept", {out_en, se_hold}, 2'b01);
    cyc(RLK + 2);
    chk("R11 released", {out_en, se_hold, d_hi, d_z}, {2'b10, 6'b0});
  endtask

  task automatic t_testmode();
    do_reset();
    powerup(3'b101, 1);
    chk("R6 test mode", test_mode, 1);
    {fs_c, fs_b, fs_a} = 3'b011; cyc(2);
    chk("R6 straps track", fs_lat, 3'b011);
    pin = 1; cyc(4);
    strobe(1, 0, 0); strobe(1, 0, 0); strobe(1, 1, 1);
    chk("R6 no power-down", {out_en, vco_en, se_hold}, 3'b110);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    cyc(1);
    t_reset();
    t_delay();
    t_frozen();
    t_decode();
    t_powerdown();
    t_testmode();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule